// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Filtering

The block receives asynchronous serial characters on a single line. It samples the line at a rate set by an external baud tick, which gives 16 samples per bit, or 8 when double speed is selected. It checks that a start bit is really present, decides each bit by a vote across three centre samples, and assembles characters of 5 to 9 data bits. An optional parity bit and one stop bit follow the data bits. A finished character is held in a one-entry buffer together with its framing and parity status. The receive-complete flag stays set until a read strobe clears it. If another character finishes while the buffer is still full, that character is lost and an overrun is flagged.

In multi-drop systems the receiver can filter on address. When filtering is on, 9-bit characters whose top bit is clear are discarded without disturbing the buffer, so only address characters wake the host. An interrupt request is raised when the receive-complete flag, its local enable and a global enable are all set. Turning the receiver off empties the buffer and clears every status flag. While the receiver is on, it claims the RX pin from normal port use.

Top module: `mpc_uart_rx`

## Requirements
- R1: After reset, rxc_o, fe_o, dor_o, upe_o, irq_o, bit9_o and data_o are all zero.
- R2: size_code_i sets the data bit count: 000=5, 001=6, 010=7, 011=8, 111=9, and any other code gives 8. Bits are received LSB first into data_o, and data_o bits above the count read zero. bit9_o carries the ninth bit in 9-bit mode and is zero otherwise.
- R3: With dbl_speed_i=0 a bit lasts 16 baud ticks. With dbl_speed_i=1 it lasts 8. Characters at either rate are decoded correctly.
- R4: A falling edge whose line is high again at the middle of the start bit is rejected, and no character results.
- R5: Each data bit is the majority of three samples at the bit centre, so a one-tick glitch at the centre does not change the bit.
- R6: parity_mode_i[1]=1 enables a parity bit after the data bits. parity_mode_i[0] selects even (0) or odd (1) parity. A mismatch sets upe_o with the character.
- R7: A stop bit sampled low sets fe_o with the character.
- R8: With mpcm_i=1 and 9-bit characters, a character whose ninth bit is 0 is discarded: rxc_o stays 0 and data_o is unchanged. A character whose ninth bit is 1 is stored. Characters of other sizes are stored normally.
- R9: A character that completes while rxc_o=1 is dropped, sets dor_o, and leaves data_o unchanged.
- R10: A pulse on rd_i clears rxc_o and dor_o.
- R11: Deasserting rx_en_i clears rxc_o, fe_o, dor_o and upe_o, and empties data_o and bit9_o.
- R12: irq_o is 1 exactly when rxc_o, rxc_ie_i and gie_i are all 1.
- R13: rx_own_o follows rx_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | One pulse per oversampling sample |
| rx_en_i | input | 1 | Receiver enable |
| dbl_speed_i | input | 1 | 8 samples per bit instead of 16 |
| mpcm_i | input | 1 | Address-filtering mode |
| size_code_i | input | 3 | Character size code |
| parity_mode_i | input | 2 | Bit 1 enable, bit 0 odd |
| rxc_ie_i | input | 1 | Receive-complete interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| rd_i | input | 1 | Buffer read strobe |
| data_o | output | 8 | Received data bits 7..0 |
| bit9_o | output | 1 | Ninth received data bit |
| rxc_o | output | 1 | Receive complete |
| fe_o | output | 1 | Framing error |
| dor_o | output | 1 | Data overrun |
| upe_o | output | 1 | Parity error |
| irq_o | output | 1 | Receive-complete interrupt request |
| rx_own_o | output | 1 | Receiver owns the RX pin |

## Verification
Two cases are hard to reach from the ports. One is a glitch that must land on exactly one of the three centre samples, even though the synchronizer delays the receiver's view of the line. The stimulus puts a one-tick inversion just past the nominal bit centre, and a single-tick pulse can reach at most one of the voted samples. The other is a filtered address frame arriving while the buffer state matters. The bench follows a stored character with a discarded one and then an overrun, and checks that data_o keeps the first value throughout.

// File: rtl/mpc_uart_rx_pkg.sv
package mpc_uart_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} rx_state_e;

  function automatic logic [3:0] size_bits(input logic [2:0] code);
    case (code)
      3'b000:  size_bits = 4'd5;
      3'b001:  size_bits = 4'd6;
      3'b010:  size_bits = 4'd7;
      3'b111:  size_bits = 4'd9;
      default: size_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/mpc_rx_sampler.sv
module mpc_rx_sampler
  import mpc_uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MAXBITS     = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               rx_i,
  input  logic               tick_i,
  input  logic               dbl_i,
  input  logic [3:0]         nbits_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  output logic               done_o,
  output logic [MAXBITS-1:0] data_o,
  output logic               fe_o,
  output logic               pe_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST_N = CW'(OSR - 1);
  localparam logic [CW-1:0] LAST_D = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] MID_N  = CW'(OSR / 2);
  localparam logic [CW-1:0] MID_D  = CW'(OSR / 4);

  logic [SYNC_STAGES-1:0] sync_q;
  logic rx_s, prev_q, vote;
  rx_state_e st_q;
  logic [CW-1:0] s_q, mid, last;
  logic [3:0] k_q;
  logic [1:0] v_q;
  logic [MAXBITS-1:0] shift_q;
  logic par_bit_q, done_q, fe_q, pe_q;

  assign rx_s = sync_q[SYNC_STAGES-1];
  assign mid  = dbl_i ? MID_D : MID_N;
  assign last = dbl_i ? LAST_D : LAST_N;
  assign vote = (v_q[0] & v_q[1]) | (v_q[0] & rx_s) | (v_q[1] & rx_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; s_q <= '0; k_q <= '0; v_q <= '0; prev_q <= 1'b1;
      shift_q <= '0; par_bit_q <= 1'b0; done_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q   <= ST_IDLE;
        prev_q <= 1'b1;
      end else if (tick_i) begin
        prev_q <= rx_s;
        case (st_q)
          ST_IDLE: if (prev_q && !rx_s) begin
            st_q <= ST_START;
            s_q  <= CW'(1);
          end
          ST_START: begin
            if (s_q == mid && rx_s) st_q <= ST_IDLE;  // false start
            else if (s_q == last) begin
              s_q <= '0; k_q <= '0; shift_q <= '0; st_q <= ST_BITS;
            end else s_q <= s_q + 1'b1;
          end
          ST_BITS: begin
            if (s_q == mid - 1'b1) v_q[0] <= rx_s;
            if (s_q == mid)        v_q[1] <= rx_s;
            if (s_q == last) begin
              s_q <= '0;
              k_q <= k_q + 1'b1;
            end else s_q <= s_q + 1'b1;
            if (s_q == mid + 1'b1) begin
              if (k_q < nbits_i) shift_q[k_q] <= vote;
              else if (k_q == nbits_i && par_en_i) par_bit_q <= vote;
              else begin
                done_q <= 1'b1;
                fe_q   <= !vote;
                pe_q   <= par_en_i && ((^shift_q ^ par_bit_q) != par_odd_i);
                st_q   <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = shift_q;
  assign fe_o   = fe_q;
  assign pe_o   = pe_q;

  // R4
  start_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && st_q == ST_START && s_q == mid && rx_s) |=> st_q == ST_IDLE);
endmodule

// File: rtl/mpc_rx_buffer.sv
module mpc_rx_buffer #(
  parameter int MAXBITS = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               done_i,
  input  logic [MAXBITS-1:0] data_i,
  input  logic               fe_i,
  input  logic               pe_i,
  input  logic [3:0]         nbits_i,
  input  logic               mpcm_i,
  input  logic               rd_i,
  input  logic               rxc_ie_i,
  input  logic               gie_i,
  output logic [7:0]         data_o,
  output logic               bit9_o,
  output logic               rxc_o,
  output logic               fe_o,
  output logic               dor_o,
  output logic               upe_o,
  output logic               irq_o
);
  logic keep, full;
  logic [7:0] data_q;
  logic bit9_q, rxc_q, fe_q, dor_q, upe_q;

  // address filter: only 9-bit frames carry the address bit
  assign keep = !(mpcm_i && nbits_i == 4'd9 && !data_i[8]);
  assign full = rxc_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0; bit9_q <= 1'b0; rxc_q <= 1'b0;
      fe_q <= 1'b0; dor_q <= 1'b0; upe_q <= 1'b0;
    end else if (!en_i) begin
      data_q <= '0; bit9_q <= 1'b0; rxc_q <= 1'b0;
      fe_q <= 1'b0; dor_q <= 1'b0; upe_q <= 1'b0;
    end else begin
      if (rd_i) begin
        rxc_q <= 1'b0;
        dor_q <= 1'b0;
      end
      if (done_i && keep) begin
        if (full) dor_q <= 1'b1;
        else begin
          data_q <= data_i[7:0];
          bit9_q <= (nbits_i == 4'd9) & data_i[8];
          fe_q   <= fe_i;
          upe_q  <= pe_i;
          rxc_q  <= 1'b1;
        end
      end
    end
  end

  assign data_o = data_q;
  assign bit9_o = bit9_q;
  assign rxc_o  = rxc_q;
  assign fe_o   = fe_q;
  assign dor_o  = dor_q;
  assign upe_o  = upe_q;
  assign irq_o  = rxc_q & rxc_ie_i & gie_i;

  // R11
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rxc_o && !fe_o && !dor_o && !upe_o && data_o == 8'd0));
  // R10
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i && !done_i) |=> (!rxc_o && !dor_o));
  // R9
  overrun_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_i && keep && rxc_q && !rd_i) |=> (dor_o && $stable(data_o)));
  // R8
  filter_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_i && mpcm_i && nbits_i == 4'd9 && !data_i[8] && !rxc_q) |=> !rxc_o);
endmodule

// File: rtl/mpc_uart_rx.sv
module mpc_uart_rx
  import mpc_uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       baud_tick_i,
  input  logic       rx_en_i,
  input  logic       dbl_speed_i,
  input  logic       mpcm_i,
  input  logic [2:0] size_code_i,
  input  logic [1:0] parity_mode_i,
  input  logic       rxc_ie_i,
  input  logic       gie_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       rxc_o,
  output logic       fe_o,
  output logic       dor_o,
  output logic       upe_o,
  output logic       irq_o,
  output logic       rx_own_o
);
  localparam int MAXBITS = 9;

  logic [3:0] nbits;
  logic done, fe, pe;
  logic [MAXBITS-1:0] frame;

  assign nbits    = size_bits(size_code_i);
  assign rx_own_o = rx_en_i;

  mpc_rx_sampler #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES), .MAXBITS(MAXBITS)) u_sampler (
    .clk_i, .rst_ni, .en_i(rx_en_i), .rx_i, .tick_i(baud_tick_i), .dbl_i(dbl_speed_i),
    .nbits_i(nbits), .par_en_i(parity_mode_i[1]), .par_odd_i(parity_mode_i[0]),
    .done_o(done), .data_o(frame), .fe_o(fe), .pe_o(pe)
  );

  mpc_rx_buffer #(.MAXBITS(MAXBITS)) u_buffer (
    .clk_i, .rst_ni, .en_i(rx_en_i), .done_i(done), .data_i(frame), .fe_i(fe), .pe_i(pe),
    .nbits_i(nbits), .mpcm_i, .rd_i, .rxc_ie_i, .gie_i,
    .data_o, .bit9_o, .rxc_o, .fe_o, .dor_o, .upe_o, .irq_o
  );
endmodule

// File: tb/mpc_uart_rx_bench.sv
module mpc_uart_rx_bench;
  typedef struct packed {
    logic [2:0] code;
    logic [1:0] par;
    logic       mpcm;
    logic       dbl;
    logic [8:0] word;
    logic       bad_par;
    logic       bad_stop;
    logic       glitch;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{3'b011, 2'b00, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0},
    '{3'b000, 2'b00, 1'b0, 1'b0, 9'h1F3, 1'b0, 1'b0, 1'b0},
    '{3'b001, 2'b10, 1'b0, 1'b0, 9'h02D, 1'b0, 1'b0, 1'b0},
    '{3'b010, 2'b11, 1'b0, 1'b1, 9'h055, 1'b0, 1'b0, 1'b0},
    '{3'b111, 2'b00, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b0, 1'b0},
    '{3'b111, 2'b00, 1'b1, 1'b0, 9'h042, 1'b0, 1'b0, 1'b0},
    '{3'b111, 2'b10, 1'b1, 1'b1, 9'h17E, 1'b0, 1'b0, 1'b0},
    '{3'b011, 2'b10, 1'b0, 1'b0, 9'h03C, 1'b1, 1'b0, 1'b0},
    '{3'b011, 2'b00, 1'b0, 1'b0, 9'h081, 1'b0, 1'b1, 1'b0},
    '{3'b011, 2'b00, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 1'b1},
    '{3'b101, 2'b00, 1'b0, 1'b0, 9'h1FF, 1'b0, 1'b0, 1'b0},
    '{3'b010, 2'b00, 1'b1, 1'b0, 9'h012, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b1, en = 1'b0;
  logic dbl = 1'b0, mpcm = 1'b0, ie = 1'b0, gie = 1'b0, rd = 1'b0;
  logic [2:0] code = 3'b011;
  logic [1:0] par = 2'b00;
  logic [7:0] data;
  logic bit9, rxc, fe, dor, upe, irq, own;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mpc_uart_rx u_mpc_uart_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .baud_tick_i(tick), .rx_en_i(en),
    .dbl_speed_i(dbl), .mpcm_i(mpcm), .size_code_i(code), .parity_mode_i(par),
    .rxc_ie_i(ie), .gie_i(gie), .rd_i(rd), .data_o(data), .bit9_o(bit9), .rxc_o(rxc),
    .fe_o(fe), .dor_o(dor), .upe_o(upe), .irq_o(irq), .rx_own_o(own)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [2:0] c);
    case (c)
      3'b000: return 5; 3'b001: return 6; 3'b010: return 7; 3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic drive(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] w, input int nb, input logic [1:0] pm,
                      input logic bad_par, input logic bad_stop, input logic glitch,
                      input logic d);
    int n;
    logic p;
    n = d ? 8 : 16;
    p = pm[0] ^ bad_par;
    drive(1'b0, n);
    for (int i = 0; i < nb; i++) begin
      p ^= w[i];
      if (glitch && i == 0) begin
        drive(w[i], n/2 + 1);
        drive(~w[i], 1);
        drive(w[i], n/2 - 2);
      end else drive(w[i], n);
    end
    if (pm[1]) drive(p, n);
    drive(!bad_stop, n);
    drive(1'b1, 2*n);
  endtask

  task automatic pulse_rd();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_data;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rxc", rxc, 0); chk("R1 data", data, 0); chk("R1 flags", {fe, dor, upe, irq, bit9}, 0);
    chk("R13 own off", own, 0);
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 own on", own, 1);

    last_data = 8'h00;
    for (int v = 0; v < NV; v++) begin
      int nb;
      logic stored;
      logic [7:0] ed;
      nb = nb_of(TBL[v].code);
      code = TBL[v].code; par = TBL[v].par; mpcm = TBL[v].mpcm; dbl = TBL[v].dbl;
      @(negedge clk);
      send(TBL[v].word, nb, TBL[v].par, TBL[v].bad_par, TBL[v].bad_stop, TBL[v].glitch, TBL[v].dbl);
      stored = !(TBL[v].mpcm && nb == 9 && !TBL[v].word[8]);
      ed = 8'(TBL[v].word & ((9'h1 << nb) - 1));
      if (stored) last_data = ed;
      // R2 R3 R5 R8 data and size, rate, voting, filtering
      chk($sformatf("R2/R8 v%0d rxc", v), rxc, stored);
      chk($sformatf("R2 v%0d data", v), data, last_data);
      if (stored) begin
        chk($sformatf("R2 v%0d bit9", v), bit9, (nb == 9) ? TBL[v].word[8] : 1'b0);
        chk($sformatf("R6 v%0d upe", v), upe, TBL[v].par[1] & TBL[v].bad_par);
        chk($sformatf("R7 v%0d fe", v), fe, TBL[v].bad_stop);
        pulse_rd();
        chk($sformatf("R10 v%0d rxc cleared", v), rxc, 0);
      end
    end

    // R12 interrupt gating
    code = 3'b011; par = 2'b00; mpcm = 1'b0; dbl = 1'b0;
    send(9'h033, 8, 2'b00, 0, 0, 0, 0);
    ie = 1'b1; gie = 1'b0; @(negedge clk);
    chk("R12 gie off", irq, 0);
    gie = 1'b1; @(negedge clk);
    chk("R12 all set", irq, 1);
    ie = 1'b0; @(negedge clk);
    chk("R12 ie off", irq, 0);
    ie = 1'b1;
    pulse_rd();
    chk("R12 after read", irq, 0);

    // R9 overrun, then R10 clear
    send(9'h011, 8, 2'b00, 0, 0, 0, 0);
    send(9'h022, 8, 2'b00, 0, 0, 0, 0);
    chk("R9 dor", dor, 1);
    chk("R9 data kept", data, 9'h011);
    pulse_rd();
    chk("R10 dor cleared", dor, 0);

    // R8 filtered frame while buffer holds data, then R11 flush
    send(9'h044, 8, 2'b00, 0, 1, 0, 0);
    code = 3'b111; mpcm = 1'b1;
    @(negedge clk);
    send(9'h099, 9, 2'b00, 0, 0, 0, 0);
    chk("R8 no overrun on filtered", dor, 0);
    chk("R8 data kept", data, 9'h044);
    send(9'h1AA, 9, 2'b00, 0, 0, 0, 0);
    chk("R9 dor set", dor, 1);
    chk("R7 fe held", fe, 1);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 flags", {rxc, fe, dor, upe}, 0);
    chk("R11 data", {bit9, data}, 0);
    chk("R13 own off", own, 0);
    en = 1'b1; mpcm = 1'b0; code = 3'b011;
    repeat (4) @(negedge clk);

    // R4 short low pulse
    drive(1'b0, 3);
    drive(1'b1, 60);
    chk("R4 no frame", rxc, 0);
    send(9'h0C6, 8, 2'b00, 0, 0, 0, 0);
    chk("R4 recovers", data, 9'h0C6);
    chk("R4 rxc", rxc, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule